// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block carries out the word-sized atomic instructions of a 32-bit RISC-V core: load-reserved, store-conditional and the nine read-modify-write AMO functions. The core hands over a decoded operation code, the address taken from rs1 and the operand taken from rs2. The unit then runs the needed accesses on a word-wide memory port and returns either a value for rd or an exception cause. It holds a single reservation bit.

Misaligned addresses and undefined operation codes are rejected before any memory access. Load-reserved reads once. Store-conditional writes once, and only when the reservation is held. An AMO reads the old word, computes the new one and writes it back. The port is held locked from the read through the write, so no other master can slip an access in between. A fault in either half of an AMO is reported as a store access fault. A failed write leaves rd unwritten.

Top module: `amo_unit`

## Requirements
- R1: An address with either of bits [1:0] set completes with `rsp_exc`=1 and makes no memory access. The cause is 4 for load-reserved (op 0) and 6 for store-conditional (op 1) and the AMOs.
- R2: Load-reserved (op 0) at an aligned address reads the word, returns it with `rsp_rd_we`=1 and sets the reservation.
- R3: A load-reserved whose read returns `mem_err` completes with cause 5 and does not write rd. It leaves the reservation clear.
- R4: Store-conditional (op 1) while the reservation is held clears the reservation, writes `req_data` to the address and returns 0 in rd.
- R5: Store-conditional without a reservation makes no write and returns 1 in rd.
- R6: A store-conditional whose write returns `mem_err` completes with cause 7 and does not write rd.
- R7: An AMO whose read returns `mem_err` completes with cause 7 (store fault, not load fault) and makes no write.
- R8: An AMO writes f(old, rs2) and returns the old word in rd. The op codes are 2 swap (writes rs2), 3 add, 4 xor, 5 and, 6 or, 7 signed min, 8 signed max, 9 unsigned min and 10 unsigned max.
- R9: An AMO whose write returns `mem_err` completes with cause 7 and `rsp_rd_we`=0.
- R10: `mem_lock` is high whenever `mem_req` is high. After an AMO read is acknowledged without error, the very next cycle carries the write request with `mem_lock` still high.
- R11: The reservation is cleared by reset, by a one-cycle `trap_in` pulse and by every exception this unit reports.
- R12: Op codes 11 to 15 complete with cause 2 and make no memory access.
- R13: `req_valid` is only taken while `busy`=0. Requests presented while busy produce no response and no access.
- R14: Each operation yields exactly one `rsp_valid` pulse one cycle wide. After reset, `busy`, `rsp_valid`, `mem_req` and `mem_lock` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an operation (taken when not busy) |
| req_op | input | 4 | Operation code |
| req_addr | input | 32 | Word address (rs1) |
| req_data | input | 32 | Operand (rs2) |
| trap_in | input | 1 | Trap taken elsewhere; clears the reservation |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_lock | output | 1 | Hold the memory for this unit |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Completing access failed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| rsp_valid | output | 1 | Result pulse |
| rsp_rd_we | output | 1 | rd is to be written |
| rsp_rd_data | output | 32 | Value for rd |
| rsp_exc | output | 1 | Exception reported |
| rsp_cause | output | 4 | Exception cause code |

## Verification
The nine AMO functions are each driven with two operand pairs. In the first pair the old word is negative and rs2 is small and positive. In the second pair the old word is small and rs2 is the most negative value. This makes the signed and unsigned minimum and maximum disagree, so a swapped comparison shows up. Memory regions that fail on every access, and regions that fail only on writes, separate read faults from write faults and load causes from store causes. Acknowledge latencies of zero to three cycles exercise the wait states and the lock across the read-to-write gap. Sequences of load-reserved followed by a trap, a reset, a faulting access or a second store-conditional show whether the reservation is set and cleared at the right moments.

// File: rtl/amo_pkg.sv
package amo_pkg;

  localparam int OP_W    = 4;
  localparam int CAUSE_W = 4;

  localparam logic [OP_W-1:0] OP_LR   = 4'd0;
  localparam logic [OP_W-1:0] OP_SC   = 4'd1;
  localparam logic [OP_W-1:0] OP_SWAP = 4'd2;
  localparam logic [OP_W-1:0] OP_ADD  = 4'd3;
  localparam logic [OP_W-1:0] OP_XOR  = 4'd4;
  localparam logic [OP_W-1:0] OP_AND  = 4'd5;
  localparam logic [OP_W-1:0] OP_OR   = 4'd6;
  localparam logic [OP_W-1:0] OP_MIN  = 4'd7;
  localparam logic [OP_W-1:0] OP_MAX  = 4'd8;
  localparam logic [OP_W-1:0] OP_MINU = 4'd9;
  localparam logic [OP_W-1:0] OP_MAXU = 4'd10;

  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 4'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_LD_ALIGN = 4'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_LD_FAULT = 4'd5;
  localparam logic [CAUSE_W-1:0] CAUSE_ST_ALIGN = 4'd6;
  localparam logic [CAUSE_W-1:0] CAUSE_ST_FAULT = 4'd7;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_READ  = 2'd1,
    S_WRITE = 2'd2,
    S_DONE  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] new_o
);

  logic lt_signed;
  logic lt_unsigned;

  always_comb begin
    lt_signed   = $signed(old_i) < $signed(opnd_i);
    lt_unsigned = old_i < opnd_i;
  end

  always_comb begin
    case (op_i)
      OP_ADD:  new_o = old_i + opnd_i;
      OP_XOR:  new_o = old_i ^ opnd_i;
      OP_AND:  new_o = old_i & opnd_i;
      OP_OR:   new_o = old_i | opnd_i;
      OP_MIN:  new_o = lt_signed   ? old_i  : opnd_i;
      OP_MAX:  new_o = lt_signed   ? opnd_i : old_i;
      OP_MINU: new_o = lt_unsigned ? old_i  : opnd_i;
      OP_MAXU: new_o = lt_unsigned ? opnd_i : old_i;
      default: new_o = opnd_i;
    endcase
  end

endmodule

// File: rtl/amo_resv.sv
module amo_resv (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic valid_o
);

  logic valid_q;
  logic valid_n;
  logic valid_en;

  always_comb begin
    valid_en = set_i | clr_i;
    valid_n  = set_i & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (valid_en) begin
      valid_q <= valid_n;
    end
  end

  assign valid_o = valid_q;

  // R11: a clear request always leaves the flag low on the next cycle
  a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !valid_q);

  // R2: a set without a clear leaves the flag high on the next cycle
  a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> valid_q);

endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  input  logic [OP_W-1:0]    req_op_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_data_i,
  output logic               busy_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic               mem_lock_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic               mem_err_i,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  input  logic               resv_i,
  output logic               resv_set_o,
  output logic               resv_clr_o,
  output logic [OP_W-1:0]    alu_op_o,
  output logic [DATA_W-1:0]  alu_old_o,
  output logic [DATA_W-1:0]  alu_opnd_o,
  input  logic [DATA_W-1:0]  alu_new_i,
  output logic               rsp_valid_o,
  output logic               rsp_rd_we_o,
  output logic [DATA_W-1:0]  rsp_rd_data_o,
  output logic               rsp_exc_o,
  output logic [CAUSE_W-1:0] rsp_cause_o
);

  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam logic [DATA_W-1:0] SC_PASS = '0;
  localparam logic [DATA_W-1:0] SC_MISS = {{(DATA_W-1){1'b0}}, 1'b1};

  seq_state_e         state_q, state_n;
  logic [OP_W-1:0]    op_q, op_n;
  logic [ADDR_W-1:0]  addr_q, addr_n;
  logic [DATA_W-1:0]  opnd_q, opnd_n;
  logic [DATA_W-1:0]  old_q, old_n;
  logic [DATA_W-1:0]  rd_q, rd_n;
  logic               rd_we_q, rd_we_n;
  logic               exc_q, exc_n;
  logic [CAUSE_W-1:0] cause_q, cause_n;
  logic               ld_req;

  logic req_lr, req_sc, req_legal, req_misal;
  logic cur_lr, cur_sc;

  always_comb begin
    req_lr    = (req_op_i == OP_LR);
    req_sc    = (req_op_i == OP_SC);
    req_legal = (req_op_i <= OP_MAXU);
    req_misal = |req_addr_i[OFF_W-1:0];
    cur_lr    = (op_q == OP_LR);
    cur_sc    = (op_q == OP_SC);
  end

  always_comb begin
    state_n     = state_q;
    op_n        = op_q;
    addr_n      = addr_q;
    opnd_n      = opnd_q;
    old_n       = old_q;
    rd_n        = rd_q;
    rd_we_n     = rd_we_q;
    exc_n       = exc_q;
    cause_n     = cause_q;
    ld_req      = 1'b0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_wdata_o = cur_sc ? opnd_q : alu_new_i;
    resv_set_o  = 1'b0;
    resv_clr_o  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (req_valid_i) begin
          ld_req  = 1'b1;
          op_n    = req_op_i;
          addr_n  = req_addr_i;
          opnd_n  = req_data_i;
          rd_n    = '0;
          rd_we_n = 1'b0;
          exc_n   = 1'b0;
          cause_n = '0;
          if (!req_legal) begin
            exc_n      = 1'b1;
            cause_n    = CAUSE_ILLEGAL;
            resv_clr_o = 1'b1;
            state_n    = S_DONE;
          end else if (req_misal) begin
            exc_n      = 1'b1;
            cause_n    = req_lr ? CAUSE_LD_ALIGN : CAUSE_ST_ALIGN;
            resv_clr_o = 1'b1;
            state_n    = S_DONE;
          end else if (req_sc) begin
            if (resv_i) begin
              resv_clr_o = 1'b1;
              state_n    = S_WRITE;
            end else begin
              rd_n    = SC_MISS;
              rd_we_n = 1'b1;
              state_n = S_DONE;
            end
          end else begin
            state_n = S_READ;
          end
        end
      end
      S_READ: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          if (mem_err_i) begin
            exc_n      = 1'b1;
            cause_n    = cur_lr ? CAUSE_LD_FAULT : CAUSE_ST_FAULT;
            resv_clr_o = 1'b1;
            state_n    = S_DONE;
          end else if (cur_lr) begin
            rd_n       = mem_rdata_i;
            rd_we_n    = 1'b1;
            resv_set_o = 1'b1;
            state_n    = S_DONE;
          end else begin
            old_n   = mem_rdata_i;
            state_n = S_WRITE;
          end
        end
      end
      S_WRITE: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_ack_i) begin
          if (mem_err_i) begin
            exc_n      = 1'b1;
            cause_n    = CAUSE_ST_FAULT;
            rd_we_n    = 1'b0;
            resv_clr_o = 1'b1;
          end else begin
            rd_n    = cur_sc ? SC_PASS : old_q;
            rd_we_n = 1'b1;
          end
          state_n = S_DONE;
        end
      end
      default: begin
        state_n = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rd_we_q <= 1'b0;
      exc_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      state_q <= state_n;
      rd_we_q <= rd_we_n;
      exc_q   <= exc_n;
      cause_q <= cause_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      addr_q <= '0;
      opnd_q <= '0;
    end else if (ld_req) begin
      op_q   <= op_n;
      addr_q <= addr_n;
      opnd_q <= opnd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q <= '0;
      rd_q  <= '0;
    end else begin
      old_q <= old_n;
      rd_q  <= rd_n;
    end
  end

  always_comb begin
    busy_o        = (state_q != S_IDLE);
    mem_lock_o    = (state_q == S_READ) || (state_q == S_WRITE);
    mem_addr_o    = addr_q;
    alu_op_o      = op_q;
    alu_old_o     = old_q;
    alu_opnd_o    = opnd_q;
    rsp_valid_o   = (state_q == S_DONE);
    rsp_rd_we_o   = rd_we_q;
    rsp_rd_data_o = rd_q;
    rsp_exc_o     = exc_q;
    rsp_cause_o   = cause_q;
  end

  // R1: a misaligned legal request ends straight away with an exception
  a_r1_misalign_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && req_valid_i && req_legal && req_misal)
      |=> (state_q == S_DONE && exc_q && !rd_we_q));

  // R5: store-conditional with no reservation returns 1 without touching memory
  a_r5_sc_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && req_valid_i && req_sc && !req_misal && !resv_i)
      |=> (state_q == S_DONE && rd_we_q && rd_q == SC_MISS));

  // R10: the write of an AMO follows its clean read with the port still locked
  a_r10_lock_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_READ && mem_ack_i && !mem_err_i && !cur_lr)
      |=> (mem_req_o && mem_we_o && mem_lock_o));

  // R9: no reported exception carries an rd write
  a_r9_fault_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_exc_o) |-> !rsp_rd_we_o);

  // R14: the response is a single-cycle pulse
  a_r14_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o);

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [OP_W-1:0]    req_op,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_data,
  input  logic               trap_in,
  output logic               busy,
  output logic               mem_req,
  output logic               mem_we,
  output logic               mem_lock,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic               mem_err,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               rsp_valid,
  output logic               rsp_rd_we,
  output logic [DATA_W-1:0]  rsp_rd_data,
  output logic               rsp_exc,
  output logic [CAUSE_W-1:0] rsp_cause
);

  logic              resv_valid;
  logic              resv_set;
  logic              seq_clr;
  logic              resv_clr;
  logic [OP_W-1:0]   alu_op;
  logic [DATA_W-1:0] alu_old;
  logic [DATA_W-1:0] alu_opnd;
  logic [DATA_W-1:0] alu_new;

  assign resv_clr = seq_clr | trap_in;

  amo_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid_i   (req_valid),
    .req_op_i      (req_op),
    .req_addr_i    (req_addr),
    .req_data_i    (req_data),
    .busy_o        (busy),
    .mem_req_o     (mem_req),
    .mem_we_o      (mem_we),
    .mem_lock_o    (mem_lock),
    .mem_addr_o    (mem_addr),
    .mem_wdata_o   (mem_wdata),
    .mem_ack_i     (mem_ack),
    .mem_err_i     (mem_err),
    .mem_rdata_i   (mem_rdata),
    .resv_i        (resv_valid),
    .resv_set_o    (resv_set),
    .resv_clr_o    (seq_clr),
    .alu_op_o      (alu_op),
    .alu_old_o     (alu_old),
    .alu_opnd_o    (alu_opnd),
    .alu_new_i     (alu_new),
    .rsp_valid_o   (rsp_valid),
    .rsp_rd_we_o   (rsp_rd_we),
    .rsp_rd_data_o (rsp_rd_data),
    .rsp_exc_o     (rsp_exc),
    .rsp_cause_o   (rsp_cause)
  );

  amo_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .op_i   (alu_op),
    .old_i  (alu_old),
    .opnd_i (alu_opnd),
    .new_o  (alu_new)
  );

  amo_resv u_resv (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (resv_set),
    .clr_i   (resv_clr),
    .valid_o (resv_valid)
  );

  // R11: while an exception response is shown, the reservation is gone
  a_r11_exc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc) |-> !resv_valid);

  // R11: a trap pulse leaves no reservation behind
  a_r11_trap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    trap_in |=> !resv_valid);

  // R10: every memory request is made under lock
  a_r10_req_locked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);

endmodule

// File: tb/amo_unit_test.sv
module amo_unit_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_op;
  logic [31:0] req_addr;
  logic [31:0] req_data;
  logic        trap_in;
  logic        busy;
  logic        mem_req;
  logic        mem_we;
  logic        mem_lock;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack;
  logic        mem_err;
  logic [31:0] mem_rdata;
  logic        rsp_valid;
  logic        rsp_rd_we;
  logic [31:0] rsp_rd_data;
  logic        rsp_exc;
  logic [3:0]  rsp_cause;

  int checks = 0;
  int errors = 0;

  // bench memory, driven by the bus
  logic [31:0] bus_mem [64];
  // model memory, updated only by the reference model
  logic [31:0] ref_mem [64];
  logic        ref_resv;

  int lat;
  int wait_cnt;
  int wr_count;
  int rsp_count;
  logic cur_amo;
  logic want_wr;
  logic lock_bad;

  amo_unit uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .req_data    (req_data),
    .trap_in     (trap_in),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_lock    (mem_lock),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .mem_err     (mem_err),
    .mem_rdata   (mem_rdata),
    .rsp_valid   (rsp_valid),
    .rsp_rd_we   (rsp_rd_we),
    .rsp_rd_data (rsp_rd_data),
    .rsp_exc     (rsp_exc),
    .rsp_cause   (rsp_cause)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // region 0xF: every access fails; region 0xE: only writes fail
  assign mem_ack   = mem_req && (wait_cnt >= lat);
  assign mem_err   = (mem_addr[31:28] == 4'hF) || (mem_we && mem_addr[31:28] == 4'hE);
  assign mem_rdata = bus_mem[mem_addr[7:2]];

  always @(posedge clk) begin
    if (mem_req && !mem_ack) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
    if (mem_req && mem_we && mem_ack && !mem_err) begin
      bus_mem[mem_addr[7:2]] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
    if (rst_n && rsp_valid) rsp_count <= rsp_count + 1;
  end

  always @(negedge clk) begin
    if (mem_req && !mem_lock) lock_bad = 1'b1;
    if (want_wr) begin
      if (!(mem_req && mem_we && mem_lock)) lock_bad = 1'b1;
      want_wr = 1'b0;
    end
    if (mem_req && !mem_we && mem_ack && !mem_err && cur_amo) want_wr = 1'b1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] amo_calc(input logic [3:0] op, input logic [31:0] o, input logic [31:0] b);
    case (op)
      4'd3:    return o + b;
      4'd4:    return o ^ b;
      4'd5:    return o & b;
      4'd6:    return o | b;
      4'd7:    return ($signed(o) < $signed(b)) ? o : b;
      4'd8:    return ($signed(o) > $signed(b)) ? o : b;
      4'd9:    return (o < b) ? o : b;
      4'd10:   return (o > b) ? o : b;
      default: return b;
    endcase
  endfunction

  task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] d,
                     input string req, input bit junk);
    logic        e_we  = 1'b0;
    logic [31:0] e_rd  = '0;
    logic        e_exc = 1'b0;
    logic [3:0]  e_cause = '0;
    int          e_wr  = 0;
    int          idx   = int'(a[7:2]);
    logic        rflt  = (a[31:28] == 4'hF);
    logic        wflt  = rflt || (a[31:28] == 4'hE);
    int          wr0;
    int          rs0;
    int          guard;
    logic [31:0] old;
    // reference model
    if (op > 4'd10) begin
      e_exc = 1'b1; e_cause = 4'd2; ref_resv = 1'b0;
    end else if (a[1:0] != 2'b00) begin
      e_exc = 1'b1; e_cause = (op == 4'd0) ? 4'd4 : 4'd6; ref_resv = 1'b0;
    end else if (op == 4'd0) begin
      if (rflt) begin
        e_exc = 1'b1; e_cause = 4'd5; ref_resv = 1'b0;
      end else begin
        e_we = 1'b1; e_rd = ref_mem[idx]; ref_resv = 1'b1;
      end
    end else if (op == 4'd1) begin
      if (!ref_resv) begin
        e_we = 1'b1; e_rd = 32'd1;
      end else begin
        ref_resv = 1'b0;
        if (wflt) begin
          e_exc = 1'b1; e_cause = 4'd7;
        end else begin
          ref_mem[idx] = d; e_we = 1'b1; e_rd = 32'd0; e_wr = 1;
        end
      end
    end else begin
      if (rflt) begin
        e_exc = 1'b1; e_cause = 4'd7; ref_resv = 1'b0;
      end else begin
        old = ref_mem[idx];
        if (wflt) begin
          e_exc = 1'b1; e_cause = 4'd7; ref_resv = 1'b0;
        end else begin
          ref_mem[idx] = amo_calc(op, old, d); e_we = 1'b1; e_rd = old; e_wr = 1;
        end
      end
    end
    // drive
    wr0 = wr_count;
    rs0 = rsp_count;
    lock_bad = 1'b0;
    cur_amo = (op >= 4'd2) && (op <= 4'd10);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    if (junk) begin
      req_op = 4'd0; req_addr = 32'hF000_0000; req_data = '1;
      @(negedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    chk(rsp_valid, {req, " response"}, {31'd0, rsp_valid}, 32'd1);
    chk(rsp_exc == e_exc && rsp_cause == e_cause, {req, " exception/cause"},
        {27'd0, rsp_exc, rsp_cause}, {27'd0, e_exc, e_cause});
    chk(rsp_rd_we == e_we, {req, " rd write enable"}, {31'd0, rsp_rd_we}, {31'd0, e_we});
    if (e_we) chk(rsp_rd_data == e_rd, {req, " rd value"}, rsp_rd_data, e_rd);
    @(negedge clk);
    chk(!rsp_valid && rsp_count == rs0 + 1, "R14 single response pulse",
        rsp_count - rs0, 32'd1);
    chk(bus_mem[idx] == ref_mem[idx], {req, " memory word"}, bus_mem[idx], ref_mem[idx]);
    chk(wr_count - wr0 == e_wr, {req, " write count"}, wr_count - wr0, e_wr);
    chk(!lock_bad, "R10 lock held", {31'd0, lock_bad}, 32'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ref_resv = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0;
    trap_in = 1'b0; lat = 0; wait_cnt = 0; wr_count = 0; rsp_count = 0;
    cur_amo = 1'b0; want_wr = 1'b0; lock_bad = 1'b0; ref_resv = 1'b0;
    for (int i = 0; i < 64; i++) begin
      bus_mem[i] = 32'h9E37_79B9 * (i + 1);
      ref_mem[i] = 32'h9E37_79B9 * (i + 1);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rsp_valid && !mem_req && !mem_lock, "R14 reset state",
        {28'd0, busy, rsp_valid, mem_req, mem_lock}, 32'd0);

    for (int l = 0; l < 4; l++) begin
      lat = l;
      run(4'd0, 32'h0000_0010, 32'd0, "R2 load-reserved", 1'b0);
      run(4'd1, 32'h0000_0010, 32'hAAAA_5555 + l, "R4 store-conditional held", 1'b0);
      run(4'd1, 32'h0000_0010, 32'h1234_5678, "R5 store-conditional after R4 clear", 1'b0);
    end

    lat = 1;
    for (int op = 2; op <= 10; op++) begin
      run(4'd2, 32'h0000_0040, 32'hFFFF_FFF0, "R8 preset negative", 1'b0);
      run(4'(op), 32'h0000_0040, 32'h0000_0005, "R8 amo negative old", 1'b0);
      run(4'd2, 32'h0000_0044, 32'h0000_0007, "R8 preset positive", 1'b0);
      run(4'(op), 32'h0000_0044, 32'h8000_0000, "R8 amo min-int operand", 1'b0);
    end

    lat = 0;
    run(4'd0, 32'h0000_0011, 32'd0, "R1 misaligned load-reserved", 1'b0);
    run(4'd1, 32'h0000_0012, 32'd9, "R1 misaligned store-conditional", 1'b0);
    run(4'd3, 32'h0000_0013, 32'd9, "R1 misaligned amo", 1'b0);

    run(4'd0, 32'h0000_0020, 32'd0, "R2 load-reserved", 1'b0);
    run(4'd0, 32'hF000_0020, 32'd0, "R3 load-reserved fault", 1'b0);
    run(4'd1, 32'h0000_0020, 32'h5A5A_5A5A, "R3 reservation not left by fault", 1'b0);

    lat = 2;
    run(4'd0, 32'hE000_0004, 32'd0, "R6 load-reserved in write-fault region", 1'b0);
    run(4'd1, 32'hE000_0004, 32'h0BAD_0BAD, "R6 store-conditional write fault", 1'b0);
    run(4'd3, 32'hF000_0008, 32'd1, "R7 amo read fault", 1'b0);
    run(4'd6, 32'hE000_0008, 32'd1, "R9 amo write fault", 1'b0);
    run(4'd12, 32'h0000_0008, 32'd1, "R12 undefined op", 1'b0);
    run(4'd15, 32'h0000_0009, 32'd1, "R12 undefined op misaligned", 1'b0);

    // R11: reservation cleared by trap, reset and own exceptions
    lat = 0;
    run(4'd0, 32'h0000_0030, 32'd0, "R2 load-reserved", 1'b0);
    @(negedge clk); trap_in = 1'b1; ref_resv = 1'b0;
    @(negedge clk); trap_in = 1'b0;
    run(4'd1, 32'h0000_0030, 32'h7777_0000, "R11 trap clears reservation", 1'b0);
    run(4'd0, 32'h0000_0030, 32'd0, "R2 load-reserved", 1'b0);
    do_reset();
    run(4'd1, 32'h0000_0030, 32'h7777_0001, "R11 reset clears reservation", 1'b0);
    run(4'd0, 32'h0000_0030, 32'd0, "R2 load-reserved", 1'b0);
    run(4'd4, 32'h0000_0032, 32'd3, "R1 misaligned amo", 1'b0);
    run(4'd1, 32'h0000_0030, 32'h7777_0002, "R11 exception clears reservation", 1'b0);

    // R13: requests while busy are ignored
    lat = 3;
    run(4'd3, 32'h0000_0048, 32'd100, "R13 request while busy ignored", 1'b1);
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req, "R13 idle after ignored request", {30'd0, busy, mem_req}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule